// File: doc/BRIEF.md
# Trap Entry Sequencer

This block computes, in one clock edge, every architectural register change an integer unit makes when it takes a trap. A trap request carries an 8-bit trap type together with the current program counter, next program counter, processor-state fields and the base of the trap table. From these inputs the block produces:

- the updated program counter, next program counter and processor-state fields;
- the new trap-table register;
- a register-file write that saves the old program counter and next program counter into the newly selected window.

External-interrupt traps are acknowledged back to the interrupt controller with their level. The surrounding pipeline chooses which trap to present. The block does not prioritise traps.

When a trap arrives while traps are disabled, no state is changed. Instead the block enters a sticky error mode. The one exception is trap type 0x80 when the shutdown option is configured; that case raises a one-cycle shutdown request.

The request side is a valid/ready interface. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is low only while error mode is set, so a stalled unit never accepts further traps. All results appear on the cycle after acceptance.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `upd_valid`, `win_we`, `ack_valid`, `shutdown_req` and `error_mode` are 0 and `req_ready` is 1.
- R2: A request accepted with `cur_et`=1 raises `upd_valid` for exactly the following cycle, with `nxt_et`=0.
- R3: The new window index is `cur_cwp`-1, wrapping from 0 to NWIN-1 (NWIN defaults to 8).
- R4: On a taken trap, `win_we` pulses together with `upd_valid`. `win_cwp` equals the new window, `win_l1_data` equals the old PC and `win_l2_data` equals the old nPC.
- R5: On a taken trap, `nxt_ps` equals the old `cur_s` and `nxt_s` is 1.
- R6: `nxt_tbr` is `{cur_tbr_base, trap_type, 4'b0000}`: the base occupies bits [31:12] and the type occupies bits [11:4].
- R7: `nxt_pc` equals `nxt_tbr` and `nxt_npc` equals `nxt_tbr`+4.
- R8: `ack_valid` pulses with the taken trap only when trap type bits [7:4] equal 4'h1. `ack_level` then carries type bits [3:0]. Any other type, including the software-trap range 0x80..0xFF, gives no acknowledge.
- R9: A request with `cur_et`=0 sets `error_mode` and causes no update, window write or acknowledge. This holds unless the type is 0x80 and `cfg_shutdown_en`=1.
- R10: A request with `cur_et`=0, type 0x80 and `cfg_shutdown_en`=1 pulses `shutdown_req` for one cycle. It leaves `error_mode` at 0 and the state outputs unchanged.
- R11: `error_mode` stays set until reset. While it is set, `req_ready` is 0 and requests change no output.
- R12: With `cur_et`=1, a software trap type (0x80..0xFF) is taken normally even when `cfg_shutdown_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Trap request present |
| req_ready | output | 1 | Request can be accepted (low in error mode) |
| req_type | input | 8 | Trap type |
| cur_pc | input | XLEN | Current program counter |
| cur_npc | input | XLEN | Current next program counter |
| cur_et | input | 1 | Traps enabled |
| cur_s | input | 1 | Current supervisor bit |
| cur_cwp | input | CWPW | Current window pointer |
| cur_tbr_base | input | XLEN-12 | Trap table base, bits [31:12] |
| cfg_shutdown_en | input | 1 | Type 0x80 with traps disabled requests shutdown |
| upd_valid | output | 1 | Next-state outputs were just updated |
| nxt_pc | output | XLEN | New program counter |
| nxt_npc | output | XLEN | New next program counter |
| nxt_et | output | 1 | New trap-enable bit |
| nxt_s | output | 1 | New supervisor bit |
| nxt_ps | output | 1 | New previous-supervisor bit |
| nxt_cwp | output | CWPW | New window pointer |
| nxt_tbr | output | XLEN | New trap-table register |
| win_we | output | 1 | Register window write strobe |
| win_cwp | output | CWPW | Window being written |
| win_l1_data | output | XLEN | Value for local register 1 (old PC) |
| win_l2_data | output | XLEN | Value for local register 2 (old nPC) |
| ack_valid | output | 1 | Interrupt acknowledge pulse |
| ack_level | output | 4 | Acknowledged interrupt level |
| error_mode | output | 1 | Sticky error state |
| shutdown_req | output | 1 | Shutdown request pulse |

## Verification
Directed scenarios use distinct window pointers, supervisor bits and table bases, so that swapped fields and unwrapped decrements show up. The window pointer 0 case exercises the wrap.

Trap types 0x0F, 0x10, 0x1F, 0x20, 0x80 and 0xFF mark the edges of the interrupt group and the software range. They separate a correct group decode from an off-by-one or a wrongly masked one.

With traps disabled, the bench covers three cases: type 0x80 with the option on, type 0x80 with the option off, and another type. These tell shutdown apart from error mode. A follow-up request then shows that error mode blocks acceptance and is cleared only by reset.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [3:0] EXT_IRQ_GROUP = 4'h1;
  localparam logic [7:0] HALT_TRAP_TT  = 8'h80;
  localparam int unsigned VEC_SHIFT    = 4;
  localparam int unsigned NPC_STEP     = 4;

  typedef enum logic [1:0] {
    DISP_TAKE  = 2'd0,
    DISP_HALT  = 2'd1,
    DISP_ERROR = 2'd2
  } disp_e;
endpackage

// File: rtl/trap_disposition.sv
module trap_disposition
  import trap_pkg::*;
(
  input  logic       et,
  input  logic [7:0] tt,
  input  logic       cfg_halt,
  output disp_e      disp,
  output logic       ack_hit
);
  always_comb begin
    if (et)                                 disp = DISP_TAKE;
    else if (tt == HALT_TRAP_TT && cfg_halt) disp = DISP_HALT;
    else                                     disp = DISP_ERROR;
  end

  assign ack_hit = et && (tt[7:4] == EXT_IRQ_GROUP);
endmodule

// File: rtl/trap_window_step.sv
module trap_window_step #(
  parameter  int NWIN = 8,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [CWPW-1:0] cwp_in,
  output logic [CWPW-1:0] cwp_out
);
  localparam logic [CWPW-1:0] TOP_WIN = CWPW'(NWIN - 1);

  generate
    if ((1 << CWPW) == NWIN) begin : g_pow2
      assign cwp_out = cwp_in - CWPW'(1);
    end else begin : g_mod
      assign cwp_out = (cwp_in == '0) ? TOP_WIN : cwp_in - CWPW'(1);
    end
  endgenerate
endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-13:0] base,
  input  logic [7:0]       tt,
  output logic [XLEN-1:0]  tbr,
  output logic [XLEN-1:0]  npc
);
  assign tbr = {base, tt, {VEC_SHIFT{1'b0}}};
  assign npc = tbr + XLEN'(NPC_STEP);
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter  int NWIN = 8,
  parameter  int XLEN = 32,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_type,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  cur_npc,
  input  logic             cur_et,
  input  logic             cur_s,
  input  logic [CWPW-1:0]  cur_cwp,
  input  logic [XLEN-13:0] cur_tbr_base,
  input  logic             cfg_shutdown_en,
  output logic             upd_valid,
  output logic [XLEN-1:0]  nxt_pc,
  output logic [XLEN-1:0]  nxt_npc,
  output logic             nxt_et,
  output logic             nxt_s,
  output logic             nxt_ps,
  output logic [CWPW-1:0]  nxt_cwp,
  output logic [XLEN-1:0]  nxt_tbr,
  output logic             win_we,
  output logic [CWPW-1:0]  win_cwp,
  output logic [XLEN-1:0]  win_l1_data,
  output logic [XLEN-1:0]  win_l2_data,
  output logic             ack_valid,
  output logic [3:0]       ack_level,
  output logic             error_mode,
  output logic             shutdown_req
);
  disp_e            disp;
  logic             ack_hit;
  logic [CWPW-1:0]  cwp_dec;
  logic [XLEN-1:0]  vec_tbr;
  logic [XLEN-1:0]  vec_npc;
  logic             accept;

  trap_disposition u_disp (
    .et       (cur_et),
    .tt       (req_type),
    .cfg_halt (cfg_shutdown_en),
    .disp     (disp),
    .ack_hit  (ack_hit)
  );

  trap_window_step #(.NWIN(NWIN)) u_win (
    .cwp_in  (cur_cwp),
    .cwp_out (cwp_dec)
  );

  trap_vector_calc #(.XLEN(XLEN)) u_vec (
    .base (cur_tbr_base),
    .tt   (req_type),
    .tbr  (vec_tbr),
    .npc  (vec_npc)
  );

  assign req_ready = !error_mode;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid    <= 1'b0;
      nxt_pc       <= '0;
      nxt_npc      <= '0;
      nxt_et       <= 1'b0;
      nxt_s        <= 1'b0;
      nxt_ps       <= 1'b0;
      nxt_cwp      <= '0;
      nxt_tbr      <= '0;
      win_we       <= 1'b0;
      win_cwp      <= '0;
      win_l1_data  <= '0;
      win_l2_data  <= '0;
      ack_valid    <= 1'b0;
      ack_level    <= '0;
      error_mode   <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      upd_valid    <= 1'b0;
      win_we       <= 1'b0;
      ack_valid    <= 1'b0;
      shutdown_req <= 1'b0;
      if (accept) begin
        unique case (disp)
          DISP_TAKE: begin
            upd_valid   <= 1'b1;
            nxt_et      <= 1'b0;
            nxt_ps      <= cur_s;
            nxt_s       <= 1'b1;
            nxt_cwp     <= cwp_dec;
            nxt_tbr     <= vec_tbr;
            nxt_pc      <= vec_tbr;
            nxt_npc     <= vec_npc;
            win_we      <= 1'b1;
            win_cwp     <= cwp_dec;
            win_l1_data <= cur_pc;
            win_l2_data <= cur_npc;
            if (ack_hit) begin
              ack_valid <= 1'b1;
              ack_level <= req_type[3:0];
            end
          end
          DISP_HALT:  shutdown_req <= 1'b1;
          default:    error_mode   <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter  int NWIN = 8,
  parameter  int XLEN = 32,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            cur_et,
  input logic [CWPW-1:0] cur_cwp,
  input logic            upd_valid,
  input logic            nxt_et,
  input logic            nxt_s,
  input logic [XLEN-1:0] nxt_pc,
  input logic [XLEN-1:0] nxt_npc,
  input logic [CWPW-1:0] nxt_cwp,
  input logic            win_we,
  input logic [CWPW-1:0] win_cwp,
  input logic            ack_valid,
  input logic            error_mode,
  input logic            shutdown_req
);
  a_r2_et_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> !nxt_et);

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cur_et && cur_cwp == '0) |=> nxt_cwp == CWPW'(NWIN - 1));

  a_r4_win_write: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (win_we && win_cwp == nxt_cwp));

  a_r5_super_set: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> nxt_s);

  a_r7_npc_step: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> nxt_npc == nxt_pc + XLEN'(4));

  a_r8_ack_with_take: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> upd_valid);

  a_r10_halt_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> (!upd_valid && !error_mode));

  a_r11_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error_mode |=> error_mode);

  a_r11_error_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    error_mode |-> !req_ready);
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .cur_et       (cur_et),
  .cur_cwp      (cur_cwp),
  .upd_valid    (upd_valid),
  .nxt_et       (nxt_et),
  .nxt_s        (nxt_s),
  .nxt_pc       (nxt_pc),
  .nxt_npc      (nxt_npc),
  .nxt_cwp      (nxt_cwp),
  .win_we       (win_we),
  .win_cwp      (win_cwp),
  .ack_valid    (ack_valid),
  .error_mode   (error_mode),
  .shutdown_req (shutdown_req)
);

// File: tb/trap_entry_seq_test.sv
`timescale 1ns/1ps
module trap_entry_seq_test;
  localparam int NWIN = 8;
  localparam int XLEN = 32;
  localparam int CWPW = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [7:0]       req_type = '0;
  logic [XLEN-1:0]  cur_pc = '0, cur_npc = '0;
  logic             cur_et = 1'b0, cur_s = 1'b0;
  logic [CWPW-1:0]  cur_cwp = '0;
  logic [XLEN-13:0] cur_tbr_base = '0;
  logic             cfg_shutdown_en = 1'b0;
  logic             upd_valid, nxt_et, nxt_s, nxt_ps, win_we, ack_valid, error_mode, shutdown_req;
  logic [XLEN-1:0]  nxt_pc, nxt_npc, nxt_tbr, win_l1_data, win_l2_data;
  logic [CWPW-1:0]  nxt_cwp, win_cwp;
  logic [3:0]       ack_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  trap_entry_seq #(.NWIN(NWIN), .XLEN(XLEN)) uut (.*);

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] tt, input logic et, input logic s,
                      input logic [CWPW-1:0] cwp, input logic [XLEN-1:0] pc,
                      input logic [XLEN-13:0] base, input logic cfg);
    @(negedge clk);
    req_type = tt; cur_et = et; cur_s = s; cur_cwp = cwp;
    cur_pc = pc; cur_npc = pc + 4; cur_tbr_base = base; cfg_shutdown_en = cfg;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic take_and_check(input logic [7:0] tt, input logic s, input logic [CWPW-1:0] cwp,
                                input logic [XLEN-1:0] pc, input logic [XLEN-13:0] base,
                                input logic cfg);
    logic [XLEN-1:0] tbr_e;
    logic [CWPW-1:0] cwp_e;
    bit ack_e;
    send(tt, 1'b1, s, cwp, pc, base, cfg);
    tbr_e = {base, tt, 4'h0};
    cwp_e = (cwp == 0) ? CWPW'(NWIN - 1) : cwp - 1;
    ack_e = (tt[7:4] == 4'h1);
    check("R2 upd_valid", XLEN'(upd_valid), 1);
    check("R2 nxt_et", XLEN'(nxt_et), 0);
    check("R3 nxt_cwp", XLEN'(nxt_cwp), XLEN'(cwp_e));
    check("R4 win_we", XLEN'(win_we), 1);
    check("R4 win_cwp", XLEN'(win_cwp), XLEN'(cwp_e));
    check("R4 win_l1_data", win_l1_data, pc);
    check("R4 win_l2_data", win_l2_data, pc + 4);
    check("R5 nxt_ps", XLEN'(nxt_ps), XLEN'(s));
    check("R5 nxt_s", XLEN'(nxt_s), 1);
    check("R6 nxt_tbr", nxt_tbr, tbr_e);
    check("R7 nxt_pc", nxt_pc, tbr_e);
    check("R7 nxt_npc", nxt_npc, tbr_e + 4);
    check("R8 ack_valid", XLEN'(ack_valid), XLEN'(ack_e));
    if (ack_e) check("R8 ack_level", XLEN'(ack_level), XLEN'(tt[3:0]));
    check("R10 no shutdown", XLEN'(shutdown_req), 0);
    @(negedge clk);
    check("R2 upd one cycle", XLEN'(upd_valid), 0);
    check("R8 ack one cycle", XLEN'(ack_valid), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 upd_valid", XLEN'(upd_valid), 0);
    check("R1 win_we", XLEN'(win_we), 0);
    check("R1 ack_valid", XLEN'(ack_valid), 0);
    check("R1 shutdown_req", XLEN'(shutdown_req), 0);
    check("R1 error_mode", XLEN'(error_mode), 0);
    check("R1 req_ready", XLEN'(req_ready), 1);
  endtask

  task automatic t_basic();
    take_and_check(8'h05, 1'b0, 3'd3, 32'h0000_4000, 20'hABCDE, 1'b0);
    take_and_check(8'h2A, 1'b1, 3'd6, 32'h1234_5678, 20'h00F00, 1'b0);
  endtask

  task automatic t_wrap();
    take_and_check(8'h07, 1'b1, 3'd0, 32'h8000_0010, 20'h55555, 1'b0);
    take_and_check(8'h03, 1'b0, 3'd7, 32'h0000_0100, 20'h00001, 1'b0);
  endtask

  task automatic t_irq_edges();
    take_and_check(8'h0F, 1'b0, 3'd2, 32'h0000_1000, 20'h11111, 1'b0);
    take_and_check(8'h10, 1'b1, 3'd4, 32'h0000_2000, 20'h22222, 1'b0);
    take_and_check(8'h1A, 1'b0, 3'd5, 32'h0000_3000, 20'h33333, 1'b0);
    take_and_check(8'h1F, 1'b1, 3'd1, 32'h0000_4000, 20'h44444, 1'b0);
    take_and_check(8'h20, 1'b0, 3'd3, 32'h0000_5000, 20'h66666, 1'b0);
  endtask

  task automatic t_software();
    take_and_check(8'h80, 1'b1, 3'd2, 32'h0000_6000, 20'h77777, 1'b1);
    check("R12 no error", XLEN'(error_mode), 0);
    take_and_check(8'hFF, 1'b0, 3'd0, 32'h0000_7000, 20'h88888, 1'b1);
  endtask

  task automatic t_shutdown();
    logic [XLEN-1:0] pc_before;
    pc_before = nxt_pc;
    send(8'h80, 1'b0, 1'b0, 3'd4, 32'h0000_9000, 20'h99999, 1'b1);
    check("R10 shutdown_req", XLEN'(shutdown_req), 1);
    check("R10 error_mode", XLEN'(error_mode), 0);
    check("R10 upd_valid", XLEN'(upd_valid), 0);
    check("R10 win_we", XLEN'(win_we), 0);
    check("R10 nxt_pc kept", nxt_pc, pc_before);
    @(negedge clk);
    check("R10 pulse ends", XLEN'(shutdown_req), 0);
  endtask

  task automatic t_error(input logic [7:0] tt, input logic cfg);
    logic [XLEN-1:0] pc_before;
    pc_before = nxt_pc;
    send(tt, 1'b0, 1'b1, 3'd5, 32'h0000_A000, 20'hAAAAA, cfg);
    check("R9 error_mode", XLEN'(error_mode), 1);
    check("R9 upd_valid", XLEN'(upd_valid), 0);
    check("R9 win_we", XLEN'(win_we), 0);
    check("R9 ack_valid", XLEN'(ack_valid), 0);
    check("R9 shutdown_req", XLEN'(shutdown_req), 0);
    check("R9 nxt_pc kept", nxt_pc, pc_before);
    check("R11 req_ready low", XLEN'(req_ready), 0);
    send(8'h12, 1'b1, 1'b0, 3'd1, 32'h0000_B000, 20'hBBBBB, 1'b0);
    check("R11 ignored upd", XLEN'(upd_valid), 0);
    check("R11 ignored ack", XLEN'(ack_valid), 0);
    check("R11 ignored pc", nxt_pc, pc_before);
    repeat (3) @(negedge clk);
    check("R11 sticky", XLEN'(error_mode), 1);
    t_reset();
    check("R11 cleared by reset", XLEN'(error_mode), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_irq_edges();
    t_software();
    t_shutdown();
    t_error(8'h80, 1'b0);
    t_error(8'h15, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule